// File: doc/BRIEF.md
# Coherence Bus Packet Framer

This block sits on a 64-bit coherence bus and cuts the stream of bus cycles into packets. The first valid cycle of a packet carries a header. The framer splits that header into its opcode, a request/reply flag, a mode-or-fault flag, a reply-shared flag, a device identifier and an address. It then looks up, from the opcode and the reply flag, how many cycles the packet lasts. Every packet is either 2 or 5 cycles long. The framer counts the cycles that follow the header, gives each one a data-word index, and marks the final cycle. Packets may follow one another with no gap. A cycle with the valid input low is an idle cycle and is skipped.

Downstream logic uses the header strobe and the held header fields to choose its coherence action. It uses the word strobe, the word index and the end strobe to steer the data words. An opcode that is not defined raises a flag, and the packet is then framed as 2 cycles so that the next packet is still found.

Top module: `bus_pkt_framer`

## Requirements
- R1: After reset, `hdr_stb`, `word_stb`, `eop` and `hdr_bad` are 0, and the first valid beat is taken as a header.
- R2: Header fields are placed in the beat as follows: opcode in bits [63:60], reply flag in bit 59 (1 = reply), mode/fault in bit 58, reply-shared in bit 57, device id in bits [56:47], and address in bits [31:0]. They appear on the outputs, together with a one-cycle `hdr_stb` pulse, one cycle after the header beat is accepted.
- R3: Opcodes 0000, 0001, 0010, 0011, 0100, 1000, 1001, 1010, 1110 and 1111 are legal. Packet lengths in beats, including the header, are:
  - 0000: 2 as a request, 5 as a reply.
  - 0001: 5 as a request, 2 as a reply.
  - 0010: 2 either way.
  - 0011: 2 as a request, 5 as a reply.
  - 0100: 5 as a request, 2 as a reply.
  - All others listed: 2.
- R4: Any other opcode sets `hdr_bad` = 1 for that packet, and the packet is framed as exactly 2 beats.
- R5: The first data beat's `word_idx` equals address bits [1:0] of the header. Each later data beat of the same packet adds 1, modulo 4.
- R6: A cycle with `in_valid` = 0 neither advances framing nor produces a strobe.
- R7: The valid beat that follows the last beat of a packet is a header, even with no idle beat between the two packets.
- R8: Every non-header beat produces a `word_stb` one cycle later, and `hdr_stb` and `word_stb` are never high together. `eop` pulses only with the last data beat.
- R9: Header outputs and `hdr_bad` hold their values until the next header is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Bus beat present |
| in_word | input | 64 | Bus beat contents |
| hdr_stb | output | 1 | Header accepted (one-cycle pulse) |
| hdr_op | output | 4 | Opcode of current packet |
| hdr_reply | output | 1 | 1 = reply, 0 = request |
| hdr_mode | output | 1 | Mode-or-fault flag |
| hdr_rshared | output | 1 | Reply-shared flag |
| hdr_dev | output | 10 | Device identifier |
| hdr_addr | output | 32 | Address |
| hdr_bad | output | 1 | Opcode undefined |
| word_stb | output | 1 | Data beat accepted (one-cycle pulse) |
| word_idx | output | 2 | Cyclic word index of that data beat |
| eop | output | 1 | Last beat of packet |

## Verification
Every result is registered once, so the outputs describing a beat are valid in the cycle after the edge that accepts it, and no later. The bench drives each beat on a falling edge, waits for the next rising edge, and samples one time unit later. Each beat is checked against the strobe, index and end flag that the bench itself computes from the length table and the address. Idle beats are checked the same way: no strobe may appear, and the held header fields must be unchanged.

// File: rtl/bus_pkt_pkg.sv
package bus_pkt_pkg;
    localparam int OP_W  = 4;
    localparam int LEN_W = 3;

    typedef enum logic [OP_W-1:0] {
        OP_RD_BLK      = 4'b0000,
        OP_WR_BLK      = 4'b0001,
        OP_WR_WORD     = 4'b0010,
        OP_CMP_WR_WORD = 4'b0011,
        OP_FLUSH       = 4'b0100,
        OP_IO_RD       = 4'b1000,
        OP_IO_WR       = 4'b1001,
        OP_IO_BCAST    = 4'b1010,
        OP_XLATE       = 4'b1110,
        OP_UNXLATE     = 4'b1111
    } op_e;

    localparam logic [LEN_W-1:0] LEN_SHORT = 3'd2;
    localparam logic [LEN_W-1:0] LEN_LONG  = 3'd5;
endpackage

// File: rtl/bus_pkt_hdr_split.sv
module bus_pkt_hdr_split #(
    parameter int WORD_W = 64,
    parameter int DEV_W  = 10,
    parameter int ADDR_W = 32
) (
    input  logic [WORD_W-1:0]            word,
    output logic [bus_pkt_pkg::OP_W-1:0] op,
    output logic                         reply,
    output logic                         mode,
    output logic                         rshared,
    output logic [DEV_W-1:0]             dev,
    output logic [ADDR_W-1:0]            addr
);
    localparam int OP_HI   = WORD_W - 1;
    localparam int REP_BIT = OP_HI - bus_pkt_pkg::OP_W;
    localparam int MOD_BIT = REP_BIT - 1;
    localparam int RSH_BIT = MOD_BIT - 1;
    localparam int DEV_HI  = RSH_BIT - 1;

    always_comb begin
        op      = word[OP_HI -: bus_pkt_pkg::OP_W];
        reply   = word[REP_BIT];
        mode    = word[MOD_BIT];
        rshared = word[RSH_BIT];
        dev     = word[DEV_HI -: DEV_W];
        addr    = word[ADDR_W-1:0];
    end
endmodule

// File: rtl/bus_pkt_len_lut.sv
module bus_pkt_len_lut
    import bus_pkt_pkg::*;
(
    input  logic [OP_W-1:0]  op,
    input  logic             reply,
    output logic [LEN_W-1:0] len,
    output logic             bad
);
    always_comb begin
        bad = 1'b0;
        len = LEN_SHORT;
        case (op)
            OP_RD_BLK:      len = reply ? LEN_LONG : LEN_SHORT;
            OP_WR_BLK:      len = reply ? LEN_SHORT : LEN_LONG;
            OP_WR_WORD:     len = LEN_SHORT;
            OP_CMP_WR_WORD: len = reply ? LEN_LONG : LEN_SHORT;
            OP_FLUSH:       len = reply ? LEN_SHORT : LEN_LONG;
            OP_IO_RD, OP_IO_WR, OP_IO_BCAST,
            OP_XLATE, OP_UNXLATE: len = LEN_SHORT;
            default:        bad = 1'b1;
        endcase
    end
endmodule

// File: rtl/bus_pkt_framer.sv
module bus_pkt_framer
    import bus_pkt_pkg::*;
#(
    parameter int WORD_W = 64,
    parameter int DEV_W  = 10,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_word,
    output logic              hdr_stb,
    output logic [OP_W-1:0]   hdr_op,
    output logic              hdr_reply,
    output logic              hdr_mode,
    output logic              hdr_rshared,
    output logic [DEV_W-1:0]  hdr_dev,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic              hdr_bad,
    output logic              word_stb,
    output logic [IDX_W-1:0]  word_idx,
    output logic              eop
);
    typedef struct packed {
        logic [LEN_W-1:0]  left;
        logic [IDX_W-1:0]  nidx;
        logic [IDX_W-1:0]  widx;
        logic              hstb;
        logic              wstb;
        logic              last;
        logic [OP_W-1:0]   op;
        logic              reply;
        logic              mode;
        logic              rsh;
        logic [DEV_W-1:0]  dev;
        logic [ADDR_W-1:0] addr;
        logic              bad;
    } frm_t;

    frm_t st_d, st_q;

    logic [OP_W-1:0]   s_op;
    logic              s_reply, s_mode, s_rsh;
    logic [DEV_W-1:0]  s_dev;
    logic [ADDR_W-1:0] s_addr;
    logic [LEN_W-1:0]  l_len;
    logic              l_bad;

    bus_pkt_hdr_split #(.WORD_W(WORD_W), .DEV_W(DEV_W), .ADDR_W(ADDR_W)) u_split (
        .word(in_word), .op(s_op), .reply(s_reply), .mode(s_mode),
        .rshared(s_rsh), .dev(s_dev), .addr(s_addr)
    );

    bus_pkt_len_lut u_lut (.op(s_op), .reply(s_reply), .len(l_len), .bad(l_bad));

    always_comb begin
        st_d      = st_q;
        st_d.hstb = 1'b0;
        st_d.wstb = 1'b0;
        st_d.last = 1'b0;
        if (in_valid) begin
            if (st_q.left == '0) begin
                st_d.hstb  = 1'b1;
                st_d.op    = s_op;
                st_d.reply = s_reply;
                st_d.mode  = s_mode;
                st_d.rsh   = s_rsh;
                st_d.dev   = s_dev;
                st_d.addr  = s_addr;
                st_d.bad   = l_bad;
                st_d.left  = l_len - LEN_W'(1);
                st_d.nidx  = s_addr[IDX_W-1:0];
            end else begin
                st_d.wstb = 1'b1;
                st_d.widx = st_q.nidx;
                st_d.nidx = st_q.nidx + IDX_W'(1);
                st_d.left = st_q.left - LEN_W'(1);
                st_d.last = (st_q.left == LEN_W'(1));
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hdr_stb     = st_q.hstb;
    assign hdr_op      = st_q.op;
    assign hdr_reply   = st_q.reply;
    assign hdr_mode    = st_q.mode;
    assign hdr_rshared = st_q.rsh;
    assign hdr_dev     = st_q.dev;
    assign hdr_addr    = st_q.addr;
    assign hdr_bad     = st_q.bad;
    assign word_stb    = st_q.wstb;
    assign word_idx    = st_q.widx;
    assign eop         = st_q.last;
endmodule

// File: rtl/bus_pkt_framer_chk.sv
module bus_pkt_framer_chk #(
    parameter int DEV_W  = 10,
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              hdr_stb,
    input logic [3:0]        hdr_op,
    input logic [DEV_W-1:0]  hdr_dev,
    input logic [ADDR_W-1:0] hdr_addr,
    input logic              hdr_bad,
    input logic              word_stb,
    input logic [IDX_W-1:0]  word_idx,
    input logic              eop
);
    logic             seen_q, after_eop_q;
    logic [IDX_W-1:0] last_idx_q;
    logic [2:0]       beats_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_q      <= 1'b0;
            after_eop_q <= 1'b0;
            last_idx_q  <= '0;
            beats_q     <= '0;
        end else begin
            if (hdr_stb) begin
                seen_q  <= 1'b0;
                beats_q <= 3'd1;
            end
            if (word_stb) begin
                seen_q     <= 1'b1;
                last_idx_q <= word_idx;
                beats_q    <= beats_q + 3'd1;
            end
            if (eop) after_eop_q <= 1'b1;
            else if (hdr_stb || word_stb) after_eop_q <= 1'b0;
        end
    end

    assert_strobes_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(hdr_stb && word_stb));
    assert_eop_on_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
        eop |-> word_stb);
    assert_idle_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!hdr_stb && !word_stb));
    assert_fields_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_stb |-> ($stable(hdr_dev) && $stable(hdr_addr) && $stable(hdr_op) && $stable(hdr_bad)));
    assert_bad_short_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && hdr_bad) |-> eop);
    assert_len_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> (beats_q <= 3'd4));
    assert_idx_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (word_stb && seen_q) |-> (word_idx == last_idx_q + IDX_W'(1)));
    assert_header_after_eop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        word_stb |-> !after_eop_q);
endmodule

bind bus_pkt_framer bus_pkt_framer_chk #(.DEV_W(DEV_W), .ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .hdr_stb(hdr_stb),
    .hdr_op(hdr_op), .hdr_dev(hdr_dev), .hdr_addr(hdr_addr), .hdr_bad(hdr_bad),
    .word_stb(word_stb), .word_idx(word_idx), .eop(eop)
);

// File: tb/bus_pkt_framer_bench.sv
`timescale 1ns/1ps
module bus_pkt_framer_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_word = '0;
    logic        hdr_stb, hdr_reply, hdr_mode, hdr_rshared, hdr_bad, word_stb, eop;
    logic [3:0]  hdr_op;
    logic [9:0]  hdr_dev;
    logic [31:0] hdr_addr;
    logic [1:0]  word_idx;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    bus_pkt_framer u_bus_pkt_framer (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_word(in_word),
        .hdr_stb(hdr_stb), .hdr_op(hdr_op), .hdr_reply(hdr_reply), .hdr_mode(hdr_mode),
        .hdr_rshared(hdr_rshared), .hdr_dev(hdr_dev), .hdr_addr(hdr_addr), .hdr_bad(hdr_bad),
        .word_stb(word_stb), .word_idx(word_idx), .eop(eop)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [63:0] mk_hdr(input logic [3:0] op, input logic rep, input logic md,
                                           input logic rs, input logic [9:0] dev, input logic [31:0] a);
        logic [63:0] w;
        w = '0;
        w[63:60] = op; w[59] = rep; w[58] = md; w[57] = rs; w[56:47] = dev; w[31:0] = a;
        return w;
    endfunction

    function automatic int exp_len(input logic [3:0] op, input logic rep);
        case (op)
            4'b0000: return rep ? 5 : 2;
            4'b0001: return rep ? 2 : 5;
            4'b0011: return rep ? 5 : 2;
            4'b0100: return rep ? 2 : 5;
            default: return 2;
        endcase
    endfunction

    function automatic bit is_legal(input logic [3:0] op);
        return op inside {4'h0, 4'h1, 4'h2, 4'h3, 4'h4, 4'h8, 4'h9, 4'hA, 4'hE, 4'hF};
    endfunction

    task automatic beat(input logic v, input logic [63:0] w);
        @(negedge clk);
        in_valid = v; in_word = w;
        @(posedge clk);
        #1;
    endtask

    task automatic idle_beat(input logic [31:0] held_addr);
        beat(1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
        check("R6 idle hdr_stb", {63'd0, hdr_stb}, 64'd0);
        check("R6 idle word_stb", {63'd0, word_stb}, 64'd0);
        check("R9 addr held over idle", {32'd0, hdr_addr}, {32'd0, held_addr});
    endtask

    task automatic run_pkt(input logic [3:0] op, input logic rep, input logic [31:0] a,
                           input logic [9:0] dev, input bit gaps);
        int len;
        len = is_legal(op) ? exp_len(op, rep) : 2;
        beat(1'b1, mk_hdr(op, rep, a[0], a[1], dev, a));
        check("R2 hdr_stb", {63'd0, hdr_stb}, 64'd1);
        check("R2 hdr_op", {60'd0, hdr_op}, {60'd0, op});
        check("R2 hdr_reply", {63'd0, hdr_reply}, {63'd0, rep});
        check("R2 hdr_mode", {63'd0, hdr_mode}, {63'd0, a[0]});
        check("R2 hdr_rshared", {63'd0, hdr_rshared}, {63'd0, a[1]});
        check("R2 hdr_dev", {54'd0, hdr_dev}, {54'd0, dev});
        check("R2 hdr_addr", {32'd0, hdr_addr}, {32'd0, a});
        check("R4 hdr_bad", {63'd0, hdr_bad}, {63'd0, !is_legal(op)});
        check("R8 no word on header", {63'd0, word_stb}, 64'd0);
        for (int k = 1; k < len; k++) begin
            if (gaps) idle_beat(a);
            beat(1'b1, {32'hDA7A_0000, 32'(k)});
            check("R8 word_stb", {63'd0, word_stb}, 64'd1);
            check("R8 no hdr on data", {63'd0, hdr_stb}, 64'd0);
            check("R5 word_idx", {62'd0, word_idx}, {62'd0, 2'(a[1:0] + 2'(k - 1))});
            check(is_legal(op) ? "R3 eop" : "R4 eop", {63'd0, eop}, {63'd0, k == len - 1});
            check("R9 dev held", {54'd0, hdr_dev}, {54'd0, dev});
        end
    endtask

    task automatic t_reset;
        rst_n = 1'b0; in_valid = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 hdr_stb", {63'd0, hdr_stb}, 64'd0);
        check("R1 word_stb", {63'd0, word_stb}, 64'd0);
        check("R1 eop", {63'd0, eop}, 64'd0);
        check("R1 hdr_bad", {63'd0, hdr_bad}, 64'd0);
        @(negedge clk); rst_n = 1'b1;
        beat(1'b1, mk_hdr(4'h8, 1'b0, 1'b0, 1'b0, 10'h3, 32'h10));
        check("R1 first beat is header", {63'd0, hdr_stb}, 64'd1);
        beat(1'b1, 64'd0);
        check("R1 second beat ends", {63'd0, eop}, 64'd1);
    endtask

    task automatic t_table;
        for (int o = 0; o < 16; o++)
            for (int r = 0; r < 2; r++)
                run_pkt(4'(o), 1'(r), 32'h100 + 32'(o * 4 + r), 10'(o * 37 + r), 1'b0);
    endtask

    task automatic t_illegal;
        run_pkt(4'h5, 1'b1, 32'h3, 10'h155, 1'b0);
        run_pkt(4'hC, 1'b0, 32'h2, 10'h2AA, 1'b0);
        run_pkt(4'h0, 1'b1, 32'h1, 10'h001, 1'b0);
    endtask

    task automatic t_gaps;
        run_pkt(4'h1, 1'b0, 32'hABCD_0003, 10'h3FF, 1'b1);
        run_pkt(4'h3, 1'b1, 32'h0000_0002, 10'h0F0, 1'b1);
        run_pkt(4'h9, 1'b0, 32'h0000_0001, 10'h00F, 1'b1);
    endtask

    task automatic t_wrap;
        run_pkt(4'h0, 1'b1, 32'hFFFF_FFFF, 10'h200, 1'b0);
        run_pkt(4'h4, 1'b0, 32'h0000_0002, 10'h201, 1'b0);
        run_pkt(4'h2, 1'b1, 32'h0000_0003, 10'h202, 1'b0);
    endtask

    initial begin
        fork
            begin
                t_reset;
                t_table;
                t_illegal;
                t_gaps;
                t_wrap;
            end
            begin
                repeat (20000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog expired");
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule